// File: doc/BRIEF.md
# Memory-Controller Performance Counter Unit

This block sits at the edge of a DRAM controller and counts what the controller does. It has a small bank of event counters. The controller feeds it a bus of single-cycle event strobes and a read and a write transaction port. Each transaction port carries a valid bit, the transaction ID and a byte count. Software sets up the unit and reads it through a plain word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the address.

Counter 0 is a fixed time base: it counts clock cycles whatever its selector holds. When it runs out, the whole bank freezes and the interrupt goes high. A measurement window therefore ends by itself. Software then reads a consistent snapshot, clears the counters and unlocks. Counters 1 to 3 each count the event that their selector names.

One ID filter, a compare value and a bit mask, is shared by the ID-qualified read and write events. When byte mode is set, those two events add the transaction's byte count instead of one per burst.

Top module: `perfmon_unit`

## Requirements
- R1: After reset every counter reads 0, the control word reads 0 and `irq` is low.
- R2: While enabled and unlocked, counter 0 advances by one per clock regardless of the value in its selector.
- R3: A selector value below EVT_W makes counter 1, 2 or 3 add one in each cycle that `evt_strobe` bit [value] is high. A selector value that is neither below EVT_W nor 0x41 or 0x42 makes the counter hold.
- R4: Selector 0x41 counts cycles with `rd_valid` high whose `rd_id` passes the filter. Selector 0x42 does the same for `wr_valid` and `wr_id`.
- R5: An ID passes when (ID & mask) == (filter ID & mask): a mask bit of 1 takes part in the compare, and a mask bit of 0 is ignored. One filter serves both 0x41 and 0x42.
- R6: With control bit 1 (byte mode) set, the 0x41 and 0x42 events add `rd_bytes` or `wr_bytes` of the matching transaction instead of one.
- R7: Counters 1 to 3 wrap modulo 2^CNT_W, keep counting, and never raise `irq`.
- R8: In a running cycle in which counter 0 holds all ones, no counter changes. From the next cycle the lock is set and `irq` is high. While the lock is set, no counter changes and status bit 4 of the control word reads 1.
- R9: A control write with bit 3 set clears the lock and `irq` in the next cycle.
- R10: A control write with bit 2 set zeroes all counters in the next cycle. This takes priority over counting. Bits 2 and 3 read back as 0.
- R11: While control bit 0 (enable) is 0, no counter changes.
- R12: Register map by `reg_addr`:
  - 0 is control (bit 0 enable, bit 1 byte mode).
  - 1 is the filter (ID in bits [ID_W-1:0], mask in bits [16+ID_W-1:16]).
  - 2 to 5 are the selectors of counters 0 to 3 (bits [7:0]).
  - 6 to 9 are the counter values, read-only.
  - Written fields read back, and unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_strobe | input | EVT_W | Single-cycle event strobes |
| rd_valid | input | 1 | Read transaction seen this cycle |
| rd_id | input | ID_W | Read transaction ID |
| rd_bytes | input | LEN_W | Read transaction byte count |
| wr_valid | input | 1 | Write transaction seen this cycle |
| wr_id | input | ID_W | Write transaction ID |
| wr_bytes | input | LEN_W | Write transaction byte count |
| irq | output | 1 | Window-expired interrupt, follows the lock |

## Verification
The bench builds the unit with 8-bit counters, 8 event strobes, 8-bit IDs and 8-bit byte counts. At that width the counter 0 expiry and lock arrive after 256 enabled cycles, so several lock and unlock rounds fit in a short run. Byte mode wraps counters 1 to 3 within a handful of transactions, which exercises the silent wrap that never raises the interrupt. The 8-bit IDs let a random ID that is biased toward the filter value hit and miss the masked compare at similar rates.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
   localparam int REG_AW = 4;
   localparam int REG_DW = 32;
   localparam int SEL_W  = 8;

   localparam logic [SEL_W-1:0] EV_RD_ID = 8'h41;
   localparam logic [SEL_W-1:0] EV_WR_ID = 8'h42;

   localparam int A_CTRL   = 0;
   localparam int A_FILT   = 1;
   localparam int SEL_BASE = 2;

   localparam int CB_EN     = 0;
   localparam int CB_BYTES  = 1;
   localparam int CB_ZERO   = 2;
   localparam int CB_UNLOCK = 3;
   localparam int CB_LOCK   = 4;
   localparam int MASK_LSB  = 16;

   typedef struct packed {
      logic bytes;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/perfmon_idmatch.sv
module perfmon_idmatch #(
   parameter int ID_W = 16
) (
   input  logic            valid,
   input  logic [ID_W-1:0] id,
   input  logic [ID_W-1:0] flt_id,
   input  logic [ID_W-1:0] flt_mask,
   output logic            hit
);
   assign hit = valid && ((id & flt_mask) == (flt_id & flt_mask));
endmodule

// File: rtl/perfmon_evsel.sv
module perfmon_evsel
   import perfmon_pkg::*;
#(
   parameter int EVT_W = 16,
   parameter int LEN_W = 8
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [EVT_W-1:0] evt,
   input  logic             rd_hit,
   input  logic             wr_hit,
   input  logic [LEN_W-1:0] rd_bytes,
   input  logic [LEN_W-1:0] wr_bytes,
   input  logic             bytes_mode,
   output logic [LEN_W-1:0] inc
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   always_comb begin
      inc = '0;
      if (sel == EV_RD_ID) begin
         if (rd_hit) inc = bytes_mode ? rd_bytes : ONE;
      end else if (sel == EV_WR_ID) begin
         if (wr_hit) inc = bytes_mode ? wr_bytes : ONE;
      end else begin
         for (int i = 0; i < EVT_W; i++) begin
            if (sel == SEL_W'(i)) inc = LEN_W'(evt[i]);
         end
      end
   end
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
   parameter int CNT_W    = 32,
   parameter int LEN_W    = 8,
   parameter bit IS_TIMER = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [LEN_W-1:0] inc,
   output logic [CNT_W-1:0] q
);
   logic [CNT_W-1:0] add;

   generate
      if (IS_TIMER) begin : g_timer
         logic unused_inc;
         assign unused_inc = ^inc;
         assign add = CNT_W'(1);
      end else begin : g_event
         assign add = CNT_W'(inc);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (clear)  q <= '0;
      else if (step)   q <= q + add;
   end
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
   import perfmon_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32,
   parameter int EVT_W   = 16,
   parameter int ID_W    = 16,
   parameter int LEN_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic [EVT_W-1:0]  evt_strobe,
   input  logic              rd_valid,
   input  logic [ID_W-1:0]   rd_id,
   input  logic [LEN_W-1:0]  rd_bytes,
   input  logic              wr_valid,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [LEN_W-1:0]  wr_bytes,
   output logic              irq
);
   localparam int CNT_BASE = SEL_BASE + NUM_CNT;

   generate
      if (NUM_CNT < 2 || CNT_BASE + NUM_CNT > (1 << REG_AW)) begin : g_bad_num
         $error("NUM_CNT out of range for the register map");
      end
      if (CNT_W < LEN_W || CNT_W > REG_DW) begin : g_bad_cnt
         $error("CNT_W must lie between LEN_W and the data width");
      end
      if (ID_W < 1 || ID_W > MASK_LSB) begin : g_bad_id
         $error("ID_W must fit in a half word");
      end
      if (EVT_W < 1 || EVT_W > int'(EV_RD_ID)) begin : g_bad_evt
         $error("EVT_W overlaps the ID event codes");
      end
   endgenerate

   ctrl_t                         ctrl_q;
   logic                          lock_q;
   logic [ID_W-1:0]               fid_q, fmask_q;
   logic [NUM_CNT-1:0][SEL_W-1:0] sel_q;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

   logic ctrl_wr, zero_wr, unlock_wr, run, expire, step;
   logic rd_hit, wr_hit;

   assign ctrl_wr   = reg_wr && (reg_addr == REG_AW'(A_CTRL));
   assign zero_wr   = ctrl_wr && reg_wdata[CB_ZERO];
   assign unlock_wr = ctrl_wr && reg_wdata[CB_UNLOCK];
   assign run       = ctrl_q.en && !lock_q;
   assign expire    = run && (cnt_q[0] == '1);
   assign step      = run && !expire;
   assign irq       = lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         lock_q  <= 1'b0;
         fid_q   <= '0;
         fmask_q <= '0;
         sel_q   <= '0;
      end else begin
         if (expire)         lock_q <= 1'b1;
         else if (unlock_wr) lock_q <= 1'b0;
         if (ctrl_wr) ctrl_q <= '{bytes: reg_wdata[CB_BYTES], en: reg_wdata[CB_EN]};
         if (reg_wr && reg_addr == REG_AW'(A_FILT)) begin
            fid_q   <= reg_wdata[ID_W-1:0];
            fmask_q <= reg_wdata[MASK_LSB +: ID_W];
         end
         for (int g = 0; g < NUM_CNT; g++) begin
            if (reg_wr && reg_addr == REG_AW'(SEL_BASE + g)) sel_q[g] <= reg_wdata[SEL_W-1:0];
         end
      end
   end

   perfmon_idmatch #(.ID_W(ID_W)) u_rd_match (
      .valid(rd_valid), .id(rd_id), .flt_id(fid_q), .flt_mask(fmask_q), .hit(rd_hit));
   perfmon_idmatch #(.ID_W(ID_W)) u_wr_match (
      .valid(wr_valid), .id(wr_id), .flt_id(fid_q), .flt_mask(fmask_q), .hit(wr_hit));

   generate
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
         logic [LEN_W-1:0] inc;
         if (g == 0) begin : g_time
            assign inc = '0;
         end else begin : g_ev
            perfmon_evsel #(.EVT_W(EVT_W), .LEN_W(LEN_W)) u_sel (
               .sel(sel_q[g]), .evt(evt_strobe), .rd_hit(rd_hit), .wr_hit(wr_hit),
               .rd_bytes(rd_bytes), .wr_bytes(wr_bytes), .bytes_mode(ctrl_q.bytes),
               .inc(inc));
         end
         perfmon_counter #(.CNT_W(CNT_W), .LEN_W(LEN_W), .IS_TIMER(g == 0)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clear(zero_wr), .step(step), .inc(inc),
            .q(cnt_q[g]));
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(A_CTRL)) begin
         reg_rdata[CB_EN]    = ctrl_q.en;
         reg_rdata[CB_BYTES] = ctrl_q.bytes;
         reg_rdata[CB_LOCK]  = lock_q;
      end
      if (reg_addr == REG_AW'(A_FILT)) begin
         reg_rdata[ID_W-1:0]       = fid_q;
         reg_rdata[MASK_LSB +: ID_W] = fmask_q;
      end
      for (int g = 0; g < NUM_CNT; g++) begin
         if (reg_addr == REG_AW'(SEL_BASE + g)) reg_rdata[SEL_W-1:0] = sel_q[g];
         if (reg_addr == REG_AW'(CNT_BASE + g)) reg_rdata[CNT_W-1:0] = cnt_q[g];
      end
   end
endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk #(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          reg_wr,
   input logic [3:0]                    reg_addr,
   input logic [1:0]                    ctl_bits,
   input logic                          en,
   input logic                          lock,
   input logic                          irq,
   input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
   logic zero_wr, unlock_wr, at_max;
   assign zero_wr   = reg_wr && reg_addr == 4'd0 && ctl_bits[0];
   assign unlock_wr = reg_wr && reg_addr == 4'd0 && ctl_bits[1];
   assign at_max    = (cnt[0] == '1);

   // R2: counter 0 advances by one per running cycle
   p_cycle_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !lock && !at_max && !zero_wr) |=> (cnt[0] == CNT_W'($past(cnt[0]) + 1'b1)));
   // R8: expiry raises the interrupt
   p_expire_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !lock && at_max) |=> irq);
   // R8: the bank is frozen while locked
   p_lock_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !zero_wr) |=> $stable(cnt));
   // R9: unlock drops the interrupt
   p_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && unlock_wr) |=> !irq);
   // R10: zeroing clears every counter
   p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      zero_wr |=> (cnt == '0));
   // R11: disabled bank holds
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !zero_wr) |=> $stable(cnt));
   // R7: only a counter 0 expiry can raise the interrupt
   p_no_wrap_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(cnt[0]) == '1));
endmodule

bind perfmon_unit perfmon_unit_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .ctl_bits(reg_wdata[3:2]), .en(ctrl_q.en), .lock(lock_q), .irq(irq), .cnt(cnt_q));

// File: tb/test_perfmon_unit.sv
`timescale 1ns/100ps
module test_perfmon_unit;
   localparam int NC = 4, CW = 8, EW = 8, IW = 8, LW = 8;
   localparam int MAXV = (1 << CW) - 1;

   logic clk = 0, rst_n = 0;
   logic reg_wr = 0;
   logic [3:0] reg_addr = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic [EW-1:0] evt = 0;
   logic rd_valid = 0, wr_valid = 0;
   logic [IW-1:0] rd_id = 0, wr_id = 0;
   logic [LW-1:0] rd_bytes = 0, wr_bytes = 0;
   logic irq;

   int tests = 0, fails = 0;
   int m_cnt[NC];
   bit m_en, m_enh, m_lock;
   bit [7:0] m_fid, m_fmask;
   bit [7:0] m_sel[NC];

   always #2 clk = ~clk;

   perfmon_unit #(.NUM_CNT(NC), .CNT_W(CW), .EVT_W(EW), .ID_W(IW), .LEN_W(LW)) i_perfmon_unit (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .evt_strobe(evt), .rd_valid(rd_valid), .rd_id(rd_id),
      .rd_bytes(rd_bytes), .wr_valid(wr_valid), .wr_id(wr_id), .wr_bytes(wr_bytes), .irq(irq));

   function automatic bit passes(bit [7:0] id);
      return (id & m_fmask) == (m_fid & m_fmask);
   endfunction

   function automatic int inc_of(bit [7:0] sel);
      if (sel == 8'h41) return (rd_valid && passes(rd_id)) ? (m_enh ? int'(rd_bytes) : 1) : 0;
      if (sel == 8'h42) return (wr_valid && passes(wr_id)) ? (m_enh ? int'(wr_bytes) : 1) : 0;
      if (sel < EW) return int'(evt[sel]);
      return 0;
   endfunction

   function automatic void model_step();
      bit run = m_en && !m_lock;
      bit ex = run && m_cnt[0] == MAXV;
      bit cw = reg_wr && reg_addr == 0;
      if (cw && reg_wdata[2]) begin
         for (int i = 0; i < NC; i++) m_cnt[i] = 0;
      end else if (run && !ex) begin
         m_cnt[0] = (m_cnt[0] + 1) & MAXV;
         for (int i = 1; i < NC; i++) m_cnt[i] = (m_cnt[i] + inc_of(m_sel[i])) & MAXV;
      end
      if (ex) m_lock = 1;
      else if (cw && reg_wdata[3]) m_lock = 0;
      if (reg_wr) begin
         if (reg_addr == 0) begin m_en = reg_wdata[0]; m_enh = reg_wdata[1]; end
         else if (reg_addr == 1) begin m_fid = reg_wdata[7:0]; m_fmask = reg_wdata[23:16]; end
         else if (reg_addr >= 2 && reg_addr < 6) m_sel[reg_addr-2] = reg_wdata[7:0];
      end
   endfunction

   function automatic bit [31:0] model_read(int a);
      if (a == 0) return {27'd0, m_lock, 2'b00, m_enh, m_en};
      if (a == 1) return {8'd0, m_fmask, 8'd0, m_fid};
      if (a >= 2 && a < 6) return {24'd0, m_sel[a-2]};
      if (a >= 6 && a < 10) return 32'(m_cnt[a-6]);
      return 0;
   endfunction

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic idle_in();
      evt = 0; rd_valid = 0; wr_valid = 0;
   endtask

   task automatic wr(int a, bit [31:0] d);
      idle_in();
      reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
      tick();
      reg_wr = 0;
   endtask

   task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic check_read(int a, string tag);
      idle_in();
      reg_addr = 4'(a);
      #1;
      check(tag, reg_rdata, model_read(a));
      tick();
   endtask

   task automatic check_all();
      check("R8 irq", 32'(irq), 32'(m_lock));
      check_read(0, "R8 ctrl");
      check_read(6, "R2 cnt0");
      check_read(7, "R3 cnt1");
      check_read(8, "R4 cnt2");
      check_read(9, "R5 cnt3");
   endtask

   task automatic rnd(int n);
      for (int k = 0; k < n; k++) begin
         evt = EW'($urandom);
         rd_valid = 1'($urandom); wr_valid = 1'($urandom);
         rd_id = ($urandom % 2) ? ((m_fid & m_fmask) | (IW'($urandom) & ~m_fmask)) : IW'($urandom);
         wr_id = ($urandom % 2) ? ((m_fid & m_fmask) | (IW'($urandom) & ~m_fmask)) : IW'($urandom);
         rd_bytes = LW'($urandom); wr_bytes = LW'($urandom);
         tick();
      end
      idle_in();
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd2417));
      for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_sel[i] = 0; end
      m_en = 0; m_enh = 0; m_lock = 0; m_fid = 0; m_fmask = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", 32'(irq), 0);
      check_read(0, "R1 ctrl");
      for (int a = 6; a < 10; a++) check_read(a, "R1 cnt");
      // R12 register map readback
      wr(1, 32'h00F0_0012);
      wr(2, 32'h05); wr(3, 32'h03); wr(4, 32'h41); wr(5, 32'h42);
      for (int a = 1; a < 6; a++) check_read(a, "R12 map");
      check_read(12, "R12 unmapped");
      // R2 R3 R4 R5 main counting, counter 0 selector ignored
      wr(0, 32'h1);
      rnd(40); check_all();
      // R5 mask: only low nibble compared, shared filter
      wr(1, 32'h000F_0005);
      rd_valid = 1; rd_id = 8'hA5; wr_valid = 1; wr_id = 8'h56; tick();
      rd_id = 8'h56; wr_id = 8'h35; tick(); idle_in();
      check_read(8, "R5 rd filter"); check_read(9, "R5 wr filter");
      // R3 unknown code holds
      wr(3, 32'h20); rnd(20); check_read(7, "R3 unknown code");
      // R6 R7 byte mode wraps without irq
      wr(0, 32'h7);
      rd_valid = 1; rd_id = 8'h05; rd_bytes = 8'd200;
      for (int k = 0; k < 3; k++) tick();
      idle_in();
      check_read(8, "R6 bytes");
      check("R7 no irq", 32'(irq), 32'(m_lock));
      rnd(30); check_all();
      // R8 expiry and lock
      wr(0, 32'h5);
      for (int k = 0; k < 260; k++) tick();
      check("R8 locked irq", 32'(irq), 1);
      rnd(25); check_all();
      // R9 unlock without zero: counter 0 still at max, re-expires
      wr(0, 32'h9); check("R9 unlock irq", 32'(irq), 0);
      tick(); check("R9 re-expire", 32'(irq), 32'(m_lock));
      // R10 zero plus unlock
      wr(0, 32'hD); check("R10 irq", 32'(irq), 0);
      check_read(6, "R10 cnt0");
      rnd(15); check_all();
      // R11 disabled
      wr(0, 32'h0); rnd(30); check_all();
      // random rounds
      for (int r = 0; r < 10; r++) begin
         wr(1, {8'd0, 8'($urandom), 8'd0, 8'($urandom)});
         for (int g = 1; g < NC; g++) begin
            bit [7:0] s;
            case ($urandom % 4)
               0: s = 8'h41;
               1: s = 8'h42;
               2: s = 8'($urandom % EW);
               default: s = 8'($urandom);
            endcase
            wr(2 + g, 32'(s));
         end
         wr(0, {28'd0, 1'b1, 1'b0, 1'($urandom), 1'($urandom % 4 != 0)});
         rnd(int'($urandom % 300));
         check_all();
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule